// File: doc/BRIEF.md
# Selectable-Polynomial CRC Attacher

This block takes a serial message, one bit per handshake, and hands it on with a cyclic redundancy check appended. The result is the input to a polar encoder. A packet is framed by a start marker and an end marker. Its parameters are sampled on the start beat: the declared message length A, a two-bit CRC mode, and a 16-bit identifier. The same shift datapath serves a 24-bit, an 11-bit and a 6-bit generator. In identifier mode, the tail of the 24-bit parity is scrambled with the identifier. In that mode a message shorter than twelve bits is also zero-filled up to twelve bits before its parity is formed.

The whole message is held in an internal bit store before any output is produced. The beat count is compared against A on the end beat. A packet whose beat count disagrees with A never reaches the output. Instead the block raises a sticky length-error flag and stops accepting input until the active-low reset is asserted. A packet that passes is replayed from the store as the message bits, then any fill bits, then the L parity bits. End-of-packet moves to the last parity bit.

The controller has six states: IDLE, CAPTURE, SEND_MSG, SEND_PAD, SEND_CRC and FAULT.
- IDLE to CAPTURE: a start beat without an end marker.
- IDLE or CAPTURE to SEND_MSG: the end beat arrives with a count equal to A.
- IDLE or CAPTURE to FAULT: the end beat arrives with any other count.
- SEND_MSG to SEND_PAD: the last message bit is taken and fill bits are due.
- SEND_MSG to SEND_CRC: the last message bit is taken and no fill is due.
- SEND_PAD to SEND_CRC: the last fill bit is taken.
- SEND_CRC to IDLE: the last parity bit is taken.
- FAULT is left only through reset.

Top module: `crc_attach`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and len_err is 0.
- R2: Mode codes 0 and 1 select the 24-bit generator 0x1B2B117, code 2 selects the 11-bit generator 0xE21 and code 3 selects the 6-bit generator 0x61. The output is the message bits in arrival order, followed by the L remainder bits of M(x)·x^L divided by the generator, highest order first. The remainder register starts at zero. K = A + L bits.
- R3: In mode 0, parity bits 9 to 24 (counting from 1 in output order) are each XORed with in_id, with bit 15 applied first. Parity bits 1 to 8 are unchanged. Mode 1 applies no identifier.
- R4: In mode 0 with A < 12, 12−A zero bits follow the message and are covered by the parity, so K = 36. No other mode inserts fill bits.
- R5: out_sop is high with the first output bit only. out_eop is high with the final parity bit only. out_valid is low in the cycle after that bit is taken.
- R6: If the beat count differs from A, or if A is 0 or above MAX_A, the packet produces no output bit. In that case len_err rises in the cycle after the end beat and stays high, and in_ready stays low, until reset.
- R7: While out_valid is high and out_ready is low, out_bit, out_sop and out_eop hold their values. in_ready is low whenever out_valid is high.
- R8: in_len, in_mode and in_id are sampled only on the start beat. Their values on later beats have no effect on the output.
- R9: A beat in IDLE without in_sop is accepted and discarded. It produces no output and does not raise len_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_bit | input | 1 | Message bit |
| in_sop | input | 1 | First bit of a packet |
| in_eop | input | 1 | Last bit of a packet |
| in_len | input | ceil(log2(MAX_A+1)) | Declared message length A |
| in_mode | input | 2 | CRC mode code |
| in_id | input | ID_W | Identifier for mode 0 |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream takes the bit |
| out_bit | output | 1 | Message, fill or parity bit |
| out_sop | output | 1 | First output bit |
| out_eop | output | 1 | Last parity bit |
| len_err | output | 1 | Sticky length-mismatch flag |

## Verification
The bench builds the block with MAX_A = 48. That store size is small enough to sweep every length from 1 to 48 in all four modes, under both a stalling and a free-running downstream. The sweep covers both sides of the twelve-bit fill threshold and every generator. The small store also puts the capacity edge within reach. A declared length of 49, and a 48-bit declaration fed 51 beats, are both driven to show that the flag fires and the store never wraps into a false match.

// File: rtl/crca_pkg.sv
package crca_pkg;

    localparam int CRC_W = 24;

    typedef enum logic [1:0] {
        MODE_ID24  = 2'd0,
        MODE_CRC24 = 2'd1,
        MODE_CRC11 = 2'd2,
        MODE_CRC6  = 2'd3
    } crc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_SEND_MSG,
        ST_SEND_PAD,
        ST_SEND_CRC,
        ST_FAULT
    } fsm_state_e;

    // Generator taps without the leading term, left-aligned to CRC_W bits.
    function automatic logic [CRC_W-1:0] poly_taps(crc_mode_e m);
        logic [CRC_W-1:0] t;
        unique case (m)
            MODE_ID24, MODE_CRC24: t = 24'hB2B117;
            MODE_CRC11:            t = {11'h621, 13'd0};
            MODE_CRC6:             t = {6'h21, 18'd0};
            default:               t = '0;
        endcase
        return t;
    endfunction

    function automatic logic [4:0] crc_bits(crc_mode_e m);
        logic [4:0] n;
        unique case (m)
            MODE_ID24, MODE_CRC24: n = 5'd24;
            MODE_CRC11:            n = 5'd11;
            MODE_CRC6:             n = 5'd6;
            default:               n = 5'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/crca_msg_store.sv
module crca_msg_store #(
    parameter int DEPTH = 1024,
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

    logic [DEPTH-1:0] mem_q;
    logic             wr_ok;
    logic             rd_ok;

    assign wr_ok = wr_en && (wr_idx < LIMIT);
    assign rd_ok = rd_idx < LIMIT;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem_q[wr_idx[AW-1:0]] <= wr_bit;
        end
    end

    assign rd_bit = rd_ok ? mem_q[rd_idx[AW-1:0]] : 1'b0;

endmodule

// File: rtl/crca_lfsr.sv
module crca_lfsr
    import crca_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             din,
    input  logic             shift,
    input  logic [CRC_W-1:0] taps,
    output logic             msb
);
    logic [CRC_W-1:0] rem_q;
    logic             fb;

    assign fb = din ^ rem_q[CRC_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (clear) begin
            rem_q <= '0;
        end else if (step) begin
            rem_q <= {rem_q[CRC_W-2:0], 1'b0} ^ (fb ? taps : '0);
        end else if (shift) begin
            rem_q <= {rem_q[CRC_W-2:0], 1'b0};
        end
    end

    assign msb = rem_q[CRC_W-1];

    // A message bit and a parity drain can never share one cycle.
    assert_step_shift_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && shift));

    // Clearing only happens on a start beat, never while bits move.
    assert_clear_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !(step || shift));

endmodule

// File: rtl/crca_ctrl.sv
module crca_ctrl
    import crca_pkg::*;
#(
    parameter int MAX_A  = 1024,
    parameter int ID_W   = 16,
    parameter int PAD_TO = 12,
    parameter int LEN_W  = 11,
    parameter int CNT_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [LEN_W-1:0] in_len,
    input  logic [1:0]       in_mode,
    input  logic [ID_W-1:0]  in_id,
    output logic             in_ready,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_bit,
    output logic             out_sop,
    output logic             out_eop,
    output logic             len_err,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_idx,
    output logic [CNT_W-1:0] rd_idx,
    input  logic             rd_bit,
    output logic             crc_clear,
    output logic             crc_step,
    output logic             crc_din,
    output logic             crc_shift,
    output logic [CRC_W-1:0] crc_taps,
    input  logic             crc_msb
);
    localparam int PAD_W = $clog2(PAD_TO + 1);
    localparam logic [LEN_W-1:0] PAD_LEN = LEN_W'(PAD_TO);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_A);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_A + 1);

    fsm_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q;
    crc_mode_e        mode_q;
    logic [CRC_W-1:0] mask_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rd_q;
    logic [PAD_W-1:0] pad_q;
    logic [4:0]       crc_q;
    logic             err_q;

    logic             in_fire, out_fire, start_beat;
    logic [LEN_W-1:0] beat_len;
    logic [CNT_W-1:0] cnt_sat, cnt_nxt;
    logic             len_ok, msg_last, pad_need, pad_last, crc_last;

    assign in_fire    = in_valid && in_ready;
    assign out_fire   = out_valid && out_ready;
    assign start_beat = (state_q == ST_IDLE) && in_fire && in_sop;

    assign cnt_sat  = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + CNT_ONE;
    assign beat_len = (state_q == ST_IDLE) ? in_len : len_q;
    assign cnt_nxt  = (state_q == ST_IDLE) ? CNT_ONE : cnt_sat;
    assign len_ok   = (beat_len <= MAX_LEN) && (cnt_nxt == CNT_W'(beat_len));

    assign msg_last = (rd_q + CNT_ONE) == CNT_W'(len_q);
    assign pad_need = (mode_q == MODE_ID24) && (len_q < PAD_LEN);
    assign pad_last = pad_q == PAD_W'(1);
    assign crc_last = crc_q == 5'd1;

    // Next-state process.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_beat) begin
                    if (in_eop) state_d = len_ok ? ST_SEND_MSG : ST_FAULT;
                    else        state_d = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                if (in_fire && in_eop) state_d = len_ok ? ST_SEND_MSG : ST_FAULT;
            end
            ST_SEND_MSG: begin
                if (out_fire && msg_last) state_d = pad_need ? ST_SEND_PAD : ST_SEND_CRC;
            end
            ST_SEND_PAD: begin
                if (out_fire && pad_last) state_d = ST_SEND_CRC;
            end
            ST_SEND_CRC: begin
                if (out_fire && crc_last) state_d = ST_IDLE;
            end
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and per-packet registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            mode_q  <= MODE_CRC24;
            mask_q  <= '0;
            cnt_q   <= '0;
            rd_q    <= '0;
            pad_q   <= '0;
            crc_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_beat) begin
                len_q  <= in_len;
                mode_q <= crc_mode_e'(in_mode);
                mask_q <= (crc_mode_e'(in_mode) == MODE_ID24) ? CRC_W'(in_id) : '0;
                cnt_q  <= CNT_ONE;
                rd_q   <= '0;
            end else if (state_q == ST_CAPTURE && in_fire) begin
                cnt_q <= cnt_sat;
            end
            if (state_d == ST_FAULT) begin
                err_q <= 1'b1;
            end
            if (state_q == ST_SEND_MSG && out_fire) begin
                rd_q <= rd_q + CNT_ONE;
                if (msg_last) pad_q <= PAD_W'(PAD_LEN - len_q);
            end
            if (state_q == ST_SEND_PAD && out_fire) begin
                pad_q <= pad_q - PAD_W'(1);
            end
            if (state_d == ST_SEND_CRC && state_q != ST_SEND_CRC) begin
                crc_q <= crc_bits(mode_q);
            end else if (state_q == ST_SEND_CRC && out_fire) begin
                crc_q  <= crc_q - 5'd1;
                mask_q <= {mask_q[CRC_W-2:0], 1'b0};
            end
        end
    end

    // Output process.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_bit   = 1'b0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        crc_step  = 1'b0;
        crc_din   = 1'b0;
        crc_shift = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CAPTURE: in_ready = 1'b1;
            ST_SEND_MSG: begin
                out_valid = 1'b1;
                out_bit   = rd_bit;
                out_sop   = rd_q == '0;
                crc_step  = out_fire;
                crc_din   = rd_bit;
            end
            ST_SEND_PAD: begin
                out_valid = 1'b1;
                crc_step  = out_fire;
            end
            ST_SEND_CRC: begin
                out_valid = 1'b1;
                out_bit   = crc_msb ^ mask_q[CRC_W-1];
                out_eop   = crc_last;
                crc_shift = out_fire;
            end
            ST_FAULT: ;
            default: ;
        endcase
    end

    assign len_err   = err_q;
    assign wr_en     = in_fire && ((state_q == ST_CAPTURE) || in_sop);
    assign wr_idx    = (state_q == ST_IDLE) ? '0 : cnt_q;
    assign rd_idx    = rd_q;
    assign crc_clear = start_beat;
    assign crc_taps  = poly_taps(mode_q);

    assert_fault_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!out_valid && !in_ready));

    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_bit) && $stable(out_sop) && $stable(out_eop)));

    assert_busy_no_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_eop_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid);

    assert_sop_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sop);

endmodule

// File: rtl/crc_attach.sv
module crc_attach
    import crca_pkg::*;
#(
    parameter int MAX_A  = 1024,
    parameter int ID_W   = 16,
    parameter int PAD_TO = 12,
    localparam int LEN_W = $clog2(MAX_A + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_bit,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [LEN_W-1:0] in_len,
    input  logic [1:0]       in_mode,
    input  logic [ID_W-1:0]  in_id,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_bit,
    output logic             out_sop,
    output logic             out_eop,
    output logic             len_err
);
    localparam int CNT_W = $clog2(MAX_A + 2);

    logic             wr_en, rd_bit;
    logic [CNT_W-1:0] wr_idx, rd_idx;
    logic             crc_clear, crc_step, crc_din, crc_shift, crc_msb;
    logic [CRC_W-1:0] crc_taps;

    crca_msg_store #(.DEPTH(MAX_A), .IDX_W(CNT_W)) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_bit (in_bit),
        .rd_idx (rd_idx),
        .rd_bit (rd_bit)
    );

    crca_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .step  (crc_step),
        .din   (crc_din),
        .shift (crc_shift),
        .taps  (crc_taps),
        .msb   (crc_msb)
    );

    crca_ctrl #(
        .MAX_A  (MAX_A),
        .ID_W   (ID_W),
        .PAD_TO (PAD_TO),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_len    (in_len),
        .in_mode   (in_mode),
        .in_id     (in_id),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .len_err   (len_err),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .rd_bit    (rd_bit),
        .crc_clear (crc_clear),
        .crc_step  (crc_step),
        .crc_din   (crc_din),
        .crc_shift (crc_shift),
        .crc_taps  (crc_taps),
        .crc_msb   (crc_msb)
    );

endmodule

// File: tb/tb_crc_attach.sv
module tb_crc_attach;
    localparam int MAX_A = 48;
    localparam int LEN_W = $clog2(MAX_A + 1);
    localparam int ID_W  = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_bit = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [LEN_W-1:0] in_len = '0;
    logic [1:0]       in_mode = '0;
    logic [ID_W-1:0]  in_id = '0;
    logic             in_ready, out_valid, out_bit, out_sop, out_eop, len_err;
    logic             out_ready = 1'b0;

    crc_attach #(.MAX_A(MAX_A), .ID_W(ID_W), .PAD_TO(12)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bit(in_bit), .in_sop(in_sop), .in_eop(in_eop), .in_len(in_len),
        .in_mode(in_mode), .in_id(in_id), .out_valid(out_valid), .out_ready(out_ready),
        .out_bit(out_bit), .out_sop(out_sop), .out_eop(out_eop), .len_err(len_err)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;
    logic exp_bits [0:127];
    logic work     [0:127];
    logic got      [0:127];
    int   got_n, eop_at, frame_bad, hold_bad;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
        end
    endtask

    initial begin
        while (!done && cyc < 190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R5 watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    function automatic logic msg_bit(int seed, int i);
        return ((i * i + 3 * i + seed) % 5) < 2;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(len_err == 1'b0, "R1 len_err", len_err, 0);
    endtask

    // Parameters on beats after the start beat are deliberately corrupted (R8).
    task automatic send_pkt(int a_decl, int nbits, int m, logic [ID_W-1:0] id, int seed);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_bit   = msg_bit(seed, i);
            in_sop   = (i == 0);
            in_eop   = (i == nbits - 1);
            if (i == 0) begin
                in_len = LEN_W'(a_decl); in_mode = 2'(m); in_id = id;
            end else begin
                in_len = ~LEN_W'(a_decl); in_mode = 2'(m) ^ 2'd1; in_id = ~id;
            end
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic recv(int a, bit stall);
        bit fin = 0, pv = 0;
        logic pb = 0, ps = 0, pe = 0;
        int guard = 0;
        got_n = 0; eop_at = -1; frame_bad = 0; hold_bad = 0;
        while (!fin && guard < 3000) begin
            if (guard > 0) @(negedge clk);
            guard++;
            out_ready = stall ? (((guard * 3 + a) % 4) != 0) : 1'b1;
            if (pv && !(out_valid && out_bit == pb && out_sop == ps && out_eop == pe)) hold_bad++;
            pv = out_valid && !out_ready;
            pb = out_bit; ps = out_sop; pe = out_eop;
            if (out_valid && out_ready) begin
                got[got_n] = out_bit;
                if (out_sop != (got_n == 0)) frame_bad++;
                if (out_eop) begin fin = 1; eop_at = got_n; end
                got_n++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(fin, "R5 packet end seen", fin, 1);
    endtask

    task automatic build_exp(int a, int m, logic [ID_W-1:0] id, int seed, output int k);
        logic [24:0] p;
        int l, n;
        if (m < 2)       begin p = 25'h1B2B117; l = 24; end
        else if (m == 2) begin p = 25'hE21;     l = 11; end
        else             begin p = 25'h61;      l = 6;  end
        n = (m == 0 && a < 12) ? 12 : a;
        for (int i = 0; i < n + l; i++) work[i] = (i < a) ? msg_bit(seed, i) : 1'b0;
        for (int i = 0; i < n; i++) exp_bits[i] = work[i];
        for (int i = 0; i < n; i++)
            if (work[i]) for (int j = 0; j <= l; j++) work[i + j] = work[i + j] ^ p[l - j];
        for (int j = 0; j < l; j++) exp_bits[n + j] = work[n + j];
        if (m == 0) for (int j = 8; j < 24; j++) exp_bits[n + j] = exp_bits[n + j] ^ id[23 - j];
        k = n + l;
    endtask

    task automatic run_pkt(int a, int m, logic [ID_W-1:0] id, bit stall);
        int seed = a * 31 + m * 7;
        int k, bad;
        string rq;
        send_pkt(a, a, m, id, seed);
        recv(a, stall);
        build_exp(a, m, id, seed, k);
        rq = (m == 0 && a < 12) ? "R4 length" : "R2 length";
        chk(got_n == k, rq, got_n, k);
        bad = -1;
        for (int i = 0; i < k && i < got_n; i++)
            if (bad < 0 && got[i] !== exp_bits[i]) bad = i;
        if (bad >= 0)
            $display("  mode %0d A %0d first bad bit %0d: actual %0b expected %0b",
                     m, a, bad, got[bad], exp_bits[bad]);
        rq = (m == 0) ? ((a < 12) ? "R4/R3/R8 content" : "R3/R8 content") : "R2/R8 content";
        chk(bad < 0, rq, bad, -1);
        chk(frame_bad == 0 && eop_at == k - 1, "R5 framing", eop_at, k - 1);
        if (stall) chk(hold_bad == 0, "R7 hold under stall", hold_bad, 0);
        chk(len_err == 1'b0, "R6 no error on good packet", len_err, 0);
    endtask

    task automatic fault_case(int a_decl, int nbits);
        bit seen = 0;
        send_pkt(a_decl, nbits, 1, 16'h1234, 5);
        repeat (40) begin
            @(negedge clk);
            if (out_valid) seen = 1;
        end
        chk(!seen, "R6 no output", seen, 0);
        chk(len_err == 1'b1, "R6 len_err", len_err, 1);
        chk(in_ready == 1'b0, "R6 in_ready low", in_ready, 0);
        do_reset();
    endtask

    initial begin
        bit seen;
        do_reset();

        // R9: stray beats without a start marker are discarded.
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 1); in_bit = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (out_valid) seen = 1;
        end
        chk(!seen, "R9 no output from stray beats", seen, 0);
        chk(len_err == 1'b0, "R9 no error from stray beats", len_err, 0);
        chk(in_ready == 1'b1, "R9 still idle", in_ready, 1);
        run_pkt(20, 0, 16'hBEEF, 1'b0);

        // Sweep every length in every mode (R2, R3, R4, R5, R7, R8).
        for (int m = 0; m < 4; m++)
            for (int a = 1; a <= MAX_A; a++)
                run_pkt(a, m, 16'hA5C3 ^ ID_W'(a * 257), (a % 2) == 1);

        // R6 corner cases.
        fault_case(20, 21);
        fault_case(30, 29);
        fault_case(0, 1);
        fault_case(MAX_A, MAX_A + 3);
        fault_case(MAX_A + 1, MAX_A + 1);
        run_pkt(7, 0, 16'h0F0F, 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule